// File: doc/BRIEF.md
# Gated Serial Clock Divider

This block derives the serial flash clock from the system clock for a flash controller's sequencer. A two-bit code selects how many system cycles each half of the serial clock lasts (1, 2, 4 or 8), so the fastest setting toggles the serial clock on every system cycle and the whole block stays in the system clock domain. One-cycle strobes mark each rising and falling edge of the serial clock. The sequencer launches on one edge and captures on the other, which gives a fixed 180-degree relation between launch and capture.

A run enable gates the clock. When the enable drops, the clock finishes its current period and halts low. A stopped flag then reports that the gate has taken effect. The host waits for this flag and for the idle flag, which mirrors the serial engine's busy line, before it changes the configuration. It then raises the enable again. The divide code is sampled only at the moment the clock restarts. A new code written while the clock runs therefore takes effect at the next restart, and no period is ever cut short.

Top module: `sclk_gate_div`

## Requirements
- R1: Asserting `rst_n` low at once forces `sclk`, `rise_stb` and `fall_stb` to 0 and `clk_stopped` and `eng_idle` to 1. Release is synchronised through two stages, so a clock enabled during reset starts on the third rising system edge after `rst_n` rises.
- R2: With divide code k (0 to 3) the serial clock is high for 2^k system cycles and low for 2^k system cycles in every period.
- R3: After a restart, `sclk` first goes high 2^k system cycles after the edge that clears `clk_stopped`.
- R4: `rise_stb` is high for exactly the first system cycle in which `sclk` is high. `fall_stb` is high for exactly the first cycle in which `sclk` is low again after a high phase. Neither strobe is high at any other time.
- R5: After `run_en` falls, the clock halts at the end of the first low system cycle of a period that is sampled with `run_en` low. Every high phase of `sclk` lasts its full 2^k cycles, including the last one.
- R6: While `run_en` stays low, `clk_stopped` stays 1 and `sclk` stays 0.
- R7: When `run_en` is sampled high while stopped, `clk_stopped` falls on that same edge.
- R8: `div_sel` is sampled only when the clock restarts. A change made while the clock runs leaves the running period lengths unchanged and is applied at the next restart.
- R9: `eng_idle` equals the inverse of `eng_busy` delayed by one system cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Divide code: half-period of 2^code system cycles |
| run_en | input | 1 | Clock run enable; low requests a clean stop |
| eng_busy | input | 1 | Serial engine has a transaction in progress |
| sclk | output | 1 | Divided serial clock, idle low |
| rise_stb | output | 1 | First cycle of each serial clock high phase |
| fall_stb | output | 1 | First cycle of each serial clock low phase |
| clk_stopped | output | 1 | Gate has taken effect and the clock is halted |
| eng_idle | output | 1 | Serial engine idle, registered |

## Verification
Each result has its own due cycle. `clk_stopped` changes one edge after `run_en` is sampled. The first rise comes 2^k edges after that. A stop lands N−t0+1 or 3N−t0+1 sampling points after the enable falls at period position t0, and `eng_idle` follows `eng_busy` by one edge. The bench drives inputs and samples outputs on falling system edges. It counts those sampling points and compares each count with the value computed from the code and the offset. Each code is swept against every stop offset inside a period. A monitor checks both strobes and the width of every high phase on every cycle.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  // Gate state: the clock is either halted low or running
  typedef enum logic {
    GATE_HALT = 1'b0,
    GATE_RUN  = 1'b1
  } gate_st_e;

endpackage

// File: rtl/sclk_rst_sync.sv
module sclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  // Shift a one in from the bottom; each stage reloads the one below it
  assign sync_d[0] = 1'b1;
  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    assign sync_d[g] = sync_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sclk_half_cnt.sv
module sclk_half_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] limit,
  output logic             tick,
  output logic             at_zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_limit;

  assign at_limit = (cnt_q == limit);
  assign at_zero  = (cnt_q == '0);
  assign tick     = cnt_en & at_limit;

  always_comb begin
    cnt_d = cnt_q;
    if (!cnt_en)       cnt_d = '0;
    else if (at_limit) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sclk_gate_ctrl.sv
module sclk_gate_ctrl
  import sclk_div_pkg::*;
#(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [CODE_W-1:0] div_sel,
  input  logic              sclk_lvl,
  input  logic              cnt_zero,
  output logic              cnt_en,
  output logic              halted,
  output logic [CODE_W-1:0] code
);

  gate_st_e          st_q, st_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              start_now;
  logic              stop_now;

  // Restart samples the divide code; stop only at a low period boundary
  assign start_now = (st_q == GATE_HALT) & run_en;
  assign stop_now  = (st_q == GATE_RUN) & ~run_en & ~sclk_lvl & cnt_zero;

  always_comb begin
    st_d   = st_q;
    code_d = code_q;
    if (start_now) begin
      st_d   = GATE_RUN;
      code_d = div_sel;
    end else if (stop_now) begin
      st_d   = GATE_HALT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= GATE_HALT;
      code_q <= '0;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
    end
  end

  assign cnt_en = (st_q == GATE_RUN) & ~stop_now;
  assign halted = (st_q == GATE_HALT);
  assign code   = code_q;

endmodule

// File: rtl/sclk_gate_div.sv
module sclk_gate_div #(
  parameter int CODE_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] div_sel,
  input  logic              run_en,
  input  logic              eng_busy,
  output logic              sclk,
  output logic              rise_stb,
  output logic              fall_stb,
  output logic              clk_stopped,
  output logic              eng_idle
);

  // Largest half-period is 2^(2^CODE_W - 1); the counter holds that minus one
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic              rst_sync_n;
  logic              cnt_en;
  logic              tick;
  logic              cnt_zero;
  logic              halted;
  logic [CODE_W-1:0] act_code;
  logic [CNT_W:0]    span;
  logic [CNT_W:0]    span_m1;
  logic [CNT_W-1:0]  limit;

  logic sclk_q, sclk_d;
  logic rise_q, rise_d;
  logic fall_q, fall_d;
  logic idle_q, idle_d;

  sclk_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sclk_gate_ctrl #(.CODE_W(CODE_W)) i_gate_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run_en   (run_en),
    .div_sel  (div_sel),
    .sclk_lvl (sclk_q),
    .cnt_zero (cnt_zero),
    .cnt_en   (cnt_en),
    .halted   (halted),
    .code     (act_code)
  );

  // Half-period length minus one, from the latched code
  assign span    = {{CNT_W{1'b0}}, 1'b1} << act_code;
  assign span_m1 = span - {{CNT_W{1'b0}}, 1'b1};
  assign limit   = span_m1[CNT_W-1:0];

  sclk_half_cnt #(.CNT_W(CNT_W)) i_half_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cnt_en  (cnt_en),
    .limit   (limit),
    .tick    (tick),
    .at_zero (cnt_zero)
  );

  // Output stage: toggle on each half-period tick, strobe the new level
  always_comb begin
    sclk_d = tick ? ~sclk_q : sclk_q;
    rise_d = tick & ~sclk_q;
    fall_d = tick & sclk_q;
    idle_d = ~eng_busy;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sclk_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      idle_q <= 1'b1;
    end else begin
      sclk_q <= sclk_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      idle_q <= idle_d;
    end
  end

  assign sclk        = sclk_q;
  assign rise_stb    = rise_q;
  assign fall_stb    = fall_q;
  assign clk_stopped = halted;
  assign eng_idle    = idle_q;

endmodule

// File: rtl/sclk_gate_div_chk.sv
module sclk_gate_div_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic eng_busy,
  input logic sclk,
  input logic rise_stb,
  input logic fall_stb,
  input logic clk_stopped,
  input logic eng_idle
);

  AST_RISE_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (sclk && !$past(sclk))); // R4
  AST_RISE_ON_EVERY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && !$past(sclk)) |-> rise_stb); // R4
  AST_FALL_ON_EVERY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk && $past(sclk)) <-> fall_stb); // R4
  AST_STOPPED_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stopped |-> !sclk); // R6
  AST_STOP_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_stopped) |-> (!$past(sclk) && !$past(run_en))); // R5
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stopped && !run_en) |=> clk_stopped); // R6
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stopped && run_en) |=> !clk_stopped); // R7
  AST_IDLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |=> !eng_idle); // R9
  AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |=> eng_idle); // R9

endmodule

bind sclk_gate_div sclk_gate_div_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .run_en      (run_en),
  .eng_busy    (eng_busy),
  .sclk        (sclk),
  .rise_stb    (rise_stb),
  .fall_stb    (fall_stb),
  .clk_stopped (clk_stopped),
  .eng_idle    (eng_idle)
);

// File: tb/test_sclk_gate_div.sv
module test_sclk_gate_div;

  localparam int CLK_PERIOD   = 10;
  localparam int WATCHDOG_CYC = 100000;
  localparam int WAIT_LIMIT   = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic       run_en = 1'b0;
  logic       eng_busy = 1'b0;
  logic       sclk;
  logic       rise_stb;
  logic       fall_stb;
  logic       clk_stopped;
  logic       eng_idle;

  int errors = 0;
  int checks = 0;
  int exp_n = 1;
  int cyc = 0;
  int hi_len = 0;
  bit mon_en = 1'b0;
  logic prev_sclk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sclk_gate_div i_sclk_gate_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_sel     (div_sel),
    .run_en      (run_en),
    .eng_busy    (eng_busy),
    .sclk        (sclk),
    .rise_stb    (rise_stb),
    .fall_stb    (fall_stb),
    .clk_stopped (clk_stopped),
    .eng_idle    (eng_idle)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Per-cycle monitor of strobes (R4) and full high phases (R5, R2)
  always @(negedge clk) begin
    if (mon_en) begin
      chk(rise_stb == (sclk && !prev_sclk), "R4 rise strobe",
          int'(rise_stb), int'(sclk && !prev_sclk));
      chk(fall_stb == (!sclk && prev_sclk), "R4 fall strobe",
          int'(fall_stb), int'(!sclk && prev_sclk));
      if (prev_sclk && !sclk)
        chk(hi_len == exp_n, "R5 high phase width", hi_len, exp_n);
    end
    hi_len    = sclk ? hi_len + 1 : 0;
    prev_sclk = sclk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG_CYC) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1-run actual=%0d expected=%0d", cyc, WATCHDOG_CYC);
      summary();
      $finish;
    end
  end

  task automatic wait_stopped(output int w);
    w = 0;
    while (!clk_stopped && w < WAIT_LIMIT) begin
      @(negedge clk);
      w++;
    end
  endtask

  // Start with code k, measure, change div_sel mid-run, stop at offset off
  task automatic run_code(input int k, input int off, input int new_sel, input bit write_sel);
    int c;
    int h;
    int l;
    int w;
    int t0;
    int exp_w;
    exp_n = 1 << k;
    if (write_sel) div_sel = 2'(k);
    run_en = 1'b1;
    @(negedge clk);
    chk(clk_stopped == 1'b0, "R7 restart one edge", int'(clk_stopped), 0);
    c = 0;
    while (!sclk && c < WAIT_LIMIT) begin
      @(negedge clk);
      c++;
    end
    chk(c == exp_n, "R3 first rise delay", c, exp_n);
    for (int p = 0; p < 3; p++) begin
      if (p == 1) div_sel = 2'(new_sel);
      h = 0;
      while (sclk && h < WAIT_LIMIT) begin
        @(negedge clk);
        h++;
      end
      l = 0;
      while (!sclk && l < WAIT_LIMIT) begin
        @(negedge clk);
        l++;
      end
      if (p == 2) begin
        chk(h == exp_n, "R8 high after mid-run code write", h, exp_n);
        chk(l == exp_n, "R8 low after mid-run code write", l, exp_n);
      end else begin
        chk(h == exp_n, "R2 high half-period", h, exp_n);
        chk(l == exp_n, "R2 low half-period", l, exp_n);
      end
    end
    // Now at period position 0 (first high cycle)
    repeat (off) @(negedge clk);
    t0 = off;
    run_en = 1'b0;
    exp_w = (t0 <= exp_n) ? (exp_n - t0 + 1) : (3 * exp_n - t0 + 1);
    wait_stopped(w);
    chk(w == exp_w, "R5 stop latency", w, exp_w);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(clk_stopped && !sclk, "R6 held stopped", int'({clk_stopped, sclk}), 2);
    end
  endtask

  initial begin
    int w;
    rst_n    = 1'b0;
    run_en   = 1'b0;
    eng_busy = 1'b0;
    div_sel  = 2'd0;
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0, "R1 reset sclk", int'(sclk), 0);
    chk(rise_stb == 1'b0 && fall_stb == 1'b0, "R1 reset strobes",
        int'({rise_stb, fall_stb}), 0);
    chk(clk_stopped == 1'b1, "R1 reset stopped", int'(clk_stopped), 1);
    chk(eng_idle == 1'b1, "R1 reset idle", int'(eng_idle), 1);

    // Synchronised release: start on the third edge after rst_n rises
    run_en = 1'b1;
    rst_n  = 1'b1;
    @(negedge clk);
    chk(clk_stopped == 1'b1, "R1 release stage 1", int'(clk_stopped), 1);
    @(negedge clk);
    chk(clk_stopped == 1'b1, "R1 release stage 2", int'(clk_stopped), 1);
    @(negedge clk);
    chk(clk_stopped == 1'b0, "R1 release start", int'(clk_stopped), 0);
    mon_en = 1'b1;
    repeat (4) @(negedge clk);
    run_en = 1'b0;
    wait_stopped(w);
    chk(clk_stopped == 1'b1, "R5 first stop", int'(clk_stopped), 1);

    // Sweep every code against every stop offset within a period
    for (int k = 0; k < 4; k++) begin
      for (int off = 0; off < 2 * (1 << k); off++) begin
        run_code(k, off, (k + 1) % 4, 1'b1);
      end
    end
    // Code written mid-run (last run wrote 0) applies at this restart: R8
    run_code(0, 1, 1, 1'b0);
    // The code 1 written mid-run above now applies: R8
    run_code(1, 3, 2, 1'b0);

    // Engine idle follows busy by one edge: R9
    for (int i = 0; i < 4; i++) begin
      eng_busy = i[0] ? 1'b0 : 1'b1;
      @(negedge clk);
      chk(eng_idle == !eng_busy, "R9 idle follows busy", int'(eng_idle), int'(!eng_busy));
    end
    eng_busy = 1'b1;
    @(negedge clk);
    eng_busy = 1'b0;
    chk(eng_idle == 1'b0, "R9 idle held low one cycle", int'(eng_idle), 0);
    @(negedge clk);
    chk(eng_idle == 1'b1, "R9 idle returns", int'(eng_idle), 1);

    // Asynchronous assertion of reset in mid high phase: R1
    eng_busy = 1'b1;
    div_sel  = 2'd2;
    run_en   = 1'b1;
    w = 0;
    while (!sclk && w < WAIT_LIMIT) begin
      @(negedge clk);
      w++;
    end
    mon_en = 1'b0;
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    chk(sclk == 1'b0, "R1 async reset sclk", int'(sclk), 0);
    chk(clk_stopped == 1'b1, "R1 async reset stopped", int'(clk_stopped), 1);
    chk(eng_idle == 1'b1, "R1 async reset idle", int'(eng_idle), 1);
    @(negedge clk);

    summary();
    $finish;
  end

endmodule